// File: doc/BRIEF.md
# Aliased Switch and LED Bus Port

This block hangs on an 8-bit processor bus with a 16-bit address, a read/not-write line and an enable strobe. It offers two locations: a read-only input port that returns the levels on eight switch pins, and a write-only output register that holds a byte for a row of LEDs. The data bus is modelled as a separate read-data output plus a read output-enable. The switches are pulled up, so a closed switch reads as a 0.

Address decoding is deliberately partial. Only five address bits are compared: the two most significant bits select the interface region 0x8000 to 0xBFFF, and bits 4, 1 and 0 pick the port. Every other address bit is a don't-care, so each port answers at 2048 alias addresses inside the region. Near neighbours that differ in bit 1 or 0, or in bit 4, do not answer.

The read path is combinational from the bus inputs. A write is captured into the output register on the rising clock edge while the write is presented.

Top module: `alias_io_port`

## Requirements
- R1: An access whose address has bits 15:14 other than binary 10 (RAM below 0x8000, ROM from 0xC000) never asserts `busRdOe` and never changes `ledOut`, whatever the other address bits are.
- R2: A read (`busRnw`=1, `busE`=1) at any address with bits 15:14=10, bit 4=1, bit 1=0, bit 0=0 (nominal 0x8010, aliases such as 0x8014, 0x8030, 0x8050) asserts `busRdOe` in the same cycle and returns `switchIn` on `busRdData`.
- R3: Reads at 0x8000, 0x8011, 0x8012 and 0x8013 do not assert `busRdOe`.
- R4: `busRdOe` is 1 only while `busRnw`=1 and `busE`=1. A write aimed at the input-port address leaves `busRdOe` at 0 and leaves `ledOut` unchanged.
- R5: A write (`busRnw`=0, `busE`=1) at any address with bits 15:14=10, bit 4=1, bit 1=0, bit 0=1 (nominal 0x8011) loads `busWrData` into `ledOut` at the next rising clock edge.
- R6: With `busE`=0, or with `busRnw`=1, the output register does not load. A read aimed at the output-register address leaves `busRdOe` at 0 and leaves `ledOut` unchanged.
- R7: `ledOut` holds its value on every cycle without a qualifying write.
- R8: `busRdData` reports each switch pin's level unchanged: a closed switch (pin 0) reads 0 and an open, pulled-up switch reads 1.
- R9: After reset `ledOut` is 0x00, and `busRdData` is 0x00 whenever `busRdOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Bus address |
| busRnw | input | 1 | 1 = read cycle, 0 = write cycle |
| busE | input | 1 | Bus enable strobe, active high |
| busWrData | input | 8 | Data written by the processor |
| switchIn | input | 8 | Switch pin levels (closed = 0) |
| busRdData | output | 8 | Read data, 0x00 when not driving |
| busRdOe | output | 1 | Read data output-enable |
| ledOut | output | 8 | Held LED byte |

## Verification
The assertions take for granted that the bus inputs are steady across each rising clock edge, so that a write seen by the combinational decode is the same one the register captures, and that `switchIn` is steady while a read is sampled. The stimulus changes every bus input only on the falling edge and samples just after the rising edge, holding each access for one full cycle. Sweeps cover every 16-bit address as a read and as a write, and every alias of both ports, with switch and write data varied from vector to vector.

// File: rtl/alias_io_pkg.sv
package alias_io_pkg;
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } io_strobe_t;
endpackage

// File: rtl/alias_io_ctrl.sv
module alias_io_ctrl
  import alias_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hC013,
  parameter logic [ADDR_W-1:0] IN_MATCH = 16'h8010,
  parameter logic [ADDR_W-1:0] OUT_MATCH = 16'h8011
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRnw,
  input  logic              busE,
  output io_strobe_t        strobes
);
  logic [ADDR_W-1:0] inBitOk;
  logic [ADDR_W-1:0] outBitOk;

  // Each compared bit must match; unmasked bits are don't-cares (aliasing).
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (DEC_MASK[i]) begin : g_cmp
      assign inBitOk[i]  = (busAddr[i] == IN_MATCH[i]);
      assign outBitOk[i] = (busAddr[i] == OUT_MATCH[i]);
    end else begin : g_free
      assign inBitOk[i]  = 1'b1;
      assign outBitOk[i] = 1'b1;
    end
  end

  logic inSel;
  logic outSel;
  assign inSel  = &inBitOk;
  assign outSel = &outBitOk;

  always_comb begin
    strobes.rdEn = inSel && busRnw && busE;
    strobes.wrEn = outSel && !busRnw && busE;
  end
endmodule

// File: rtl/alias_io_dp.sv
module alias_io_dp
  import alias_io_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  io_strobe_t        strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] switchIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdOe,
  output logic [DATA_W-1:0] ledOut
);
  logic [DATA_W-1:0] ledReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ledReg <= '0;
    else if (strobes.wrEn) ledReg <= busWrData;
  end

  assign ledOut    = ledReg;
  assign busRdOe   = strobes.rdEn;
  assign busRdData = strobes.rdEn ? switchIn : '0;
endmodule

// File: rtl/alias_io_port.sv
module alias_io_port
  import alias_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'hC013,
  parameter logic [ADDR_W-1:0] IN_MATCH = 16'h8010,
  parameter logic [ADDR_W-1:0] OUT_MATCH = 16'h8011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRnw,
  input  logic              busE,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] switchIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdOe,
  output logic [DATA_W-1:0] ledOut
);
  io_strobe_t strobes;

  alias_io_ctrl #(
    .ADDR_W(ADDR_W), .DEC_MASK(DEC_MASK),
    .IN_MATCH(IN_MATCH), .OUT_MATCH(OUT_MATCH)
  ) u_ctrl (
    .busAddr(busAddr), .busRnw(busRnw), .busE(busE), .strobes(strobes)
  );

  alias_io_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busWrData(busWrData), .switchIn(switchIn),
    .busRdData(busRdData), .busRdOe(busRdOe), .ledOut(ledOut)
  );
endmodule

// File: rtl/alias_io_chk.sv
module alias_io_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRnw,
  input logic              busE,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] switchIn,
  input logic [DATA_W-1:0] busRdData,
  input logic              busRdOe,
  input logic [DATA_W-1:0] ledOut
);
  logic regionHit;
  logic wrHit;
  assign regionHit = (busAddr[ADDR_W-1 -: 2] == 2'b10);
  assign wrHit = regionHit && busAddr[4] && !busAddr[1] && busAddr[0] && !busRnw && busE;

  assert_rd_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRdOe |-> (busRnw && busE));
  assert_rd_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdOe |-> (regionHit && busAddr[4] && !busAddr[1] && !busAddr[0]));
  assert_region_R1: assert property (@(posedge clk) disable iff (!rstN)
    !regionHit |-> !busRdOe);
  assert_rd_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    busRdOe |-> (busRdData == switchIn));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdOe |-> (busRdData == '0));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> (ledOut == $past(busWrData)));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(ledOut));
endmodule

bind alias_io_port alias_io_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRnw(busRnw), .busE(busE),
  .busWrData(busWrData), .switchIn(switchIn), .busRdData(busRdData),
  .busRdOe(busRdOe), .ledOut(ledOut)
);

// File: tb/alias_io_port_tb.sv
module alias_io_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busRnw = 1'b1;
  logic busE = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] switchIn = 8'hFF;
  logic [7:0] busRdData;
  logic busRdOe;
  logic [7:0] ledOut;

  always #2 clk = ~clk;  // 250 MHz

  alias_io_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRnw(busRnw), .busE(busE),
    .busWrData(busWrData), .switchIn(switchIn), .busRdData(busRdData),
    .busRdOe(busRdOe), .ledOut(ledOut)
  );

  typedef struct {
    logic       oe;
    logic [7:0] rd;
    logic [7:0] led;
    string      req;
  } exp_t;

  exp_t expQ[$];
  event sampleEv;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] ledModel = 8'h00;
  bit done = 0;

  function automatic string reqFor(logic [15:0] a, logic rnw, logic e);
    bit reg10 = (a[15:14] == 2'b10);
    if (!reg10) return "R1";
    if (a[4] && !a[1] && !a[0]) return (rnw && e) ? "R2" : (rnw ? "R4" : "R4");
    if (a[4] && !a[1] && a[0]) return (!rnw && e) ? "R5" : "R6";
    return "R3";
  endfunction

  task automatic busCycle(input logic [15:0] a, input logic rnw, input logic e,
                          input logic [7:0] wd, input logic [7:0] sw, input string req);
    exp_t it;
    bit inHit, outHit;
    @(negedge clk);
    busAddr = a; busRnw = rnw; busE = e; busWrData = wd; switchIn = sw;
    inHit  = (a[15:14] == 2'b10) && a[4] && !a[1] && !a[0];
    outHit = (a[15:14] == 2'b10) && a[4] && !a[1] && a[0];
    it.oe = inHit && rnw && e;
    it.rd = it.oe ? sw : 8'h00;
    if (outHit && !rnw && e) ledModel = wd;
    it.led = ledModel;
    it.req = req;
    expQ.push_back(it);
    @(posedge clk);
    #1;
    -> sampleEv;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(sampleEv);
      it = expQ.pop_front();
      nChecks++;
      if (busRdOe !== it.oe || busRdData !== it.rd || ledOut !== it.led) begin
        nFails++;
        $display("FAIL %s addr=%h rnw=%b e=%b: oe/rd/led actual %b/%h/%h expected %b/%h/%h",
                 it.req, busAddr, busRnw, busE, busRdOe, busRdData, ledOut, it.oe, it.rd, it.led);
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : driver
    // R9: reset state
    repeat (2) @(posedge clk);
    #1;
    nChecks++;
    if (ledOut !== 8'h00 || busRdOe !== 1'b0 || busRdData !== 8'h00) begin
      nFails++;
      $display("FAIL R9 reset: led/oe/rd actual %h/%b/%h expected 00/0/00", ledOut, busRdOe, busRdData);
    end
    @(negedge clk); rstN = 1'b1;

    // Directed corners
    busCycle(16'h8010, 1, 1, 8'h00, 8'hA5, "R2");
    busCycle(16'h8030, 1, 1, 8'h00, 8'h3C, "R2");
    busCycle(16'h8050, 1, 1, 8'h00, 8'h0F, "R2");
    busCycle(16'h8014, 1, 1, 8'h00, 8'hF0, "R2");
    busCycle(16'h8010, 1, 1, 8'h00, 8'hFE, "R8 switch0 closed");
    busCycle(16'h8010, 1, 1, 8'h00, 8'h00, "R8 all closed");
    busCycle(16'h8011, 1, 1, 8'h00, 8'h55, "R3/R6");
    busCycle(16'h8012, 1, 1, 8'h00, 8'h55, "R3");
    busCycle(16'h8013, 1, 1, 8'h00, 8'h55, "R3");
    busCycle(16'h8000, 1, 1, 8'h00, 8'h55, "R3");
    busCycle(16'h8010, 1, 0, 8'h00, 8'h55, "R4 E low");
    busCycle(16'h8011, 0, 1, 8'h6B, 8'h55, "R5");
    busCycle(16'h8010, 0, 1, 8'h99, 8'h55, "R4 write to input");
    busCycle(16'h8011, 0, 0, 8'h11, 8'h55, "R6 E low");
    busCycle(16'h8011, 1, 1, 8'h22, 8'h55, "R6 read of output");
    busCycle(16'h0011, 0, 1, 8'h33, 8'h55, "R1 RAM");
    busCycle(16'hC011, 0, 1, 8'h44, 8'h55, "R1 ROM");
    busCycle(16'h4010, 1, 1, 8'h00, 8'h55, "R1 RAM read");
    repeat (3) busCycle(16'h8012, 0, 1, 8'h77, 8'h55, "R7 hold");
    busCycle(16'hBFF1, 0, 1, 8'hC3, 8'h55, "R5 top alias");

    // Every alias of both ports, read and write each
    for (int k = 0; k < 2048; k++) begin
      logic [15:0] base;
      base = {2'b10, k[10:2], 1'b1, k[1:0], 2'b00};
      busCycle(base, 1, 1, 8'(k * 7), 8'(k ^ 8'h5A), "R2 alias");
      busCycle(base | 16'h0001, 1, 1, 8'(k * 3), 8'(k), "R6 alias read");
      busCycle(base | 16'h0001, 0, 1, 8'(k * 5 + 1), 8'(k), "R5 alias");
      busCycle(base, 0, 1, 8'(k * 11), 8'(k), "R4 alias write");
    end

    // Full address sweep, reads then writes
    for (int a = 0; a < 65536; a++)
      busCycle(16'(a), 1, 1, 8'h00, 8'(a ^ (a >> 8)), reqFor(16'(a), 1, 1));
    for (int a = 0; a < 65536; a++)
      busCycle(16'(a), 0, (a % 3) != 0, 8'(a * 13), 8'hFF, reqFor(16'(a), 0, (a % 3) != 0));

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule